// File: doc/BRIEF.md
# Microstep Position Indexer

This block holds the electrical position of a two-phase stepper motor and turns it into current setpoints for both windings. A step pulse moves a 6-bit position index around a 64-slot electrical cycle. The distance of each move depends on a 3-bit resolution code, which ranges from full step to one-sixteenth step. A direction level decides whether the index counts up or down. From the index, the block derives an 8-bit magnitude for each winding, given as a percent of the maximum trip current, plus a polarity bit for each winding.

The step and direction inputs can come from another clock domain. Both pass through the same two-flop synchroniser, so they stay aligned with each other. The index moves only on a rising step edge detected after that synchroniser. This means a change on the direction input alone does nothing until the next step edge. A full-step flag tells the downstream decay selector to force slow decay. Digital-to-analog conversion, the current reference and the power bridge are outside this block.

Top module: `microstep_indexer`

## Requirements
- R1: While rst_ni is low, the index is 8 (the 45-degree home slot), both magnitudes are 71, both polarity bits are 1 and full_step_o is 0.
- R2: With direction 1, each detected rising step edge adds the increment to the index. The increment is 16 for resolution code 0 (full), 8 for code 1 (half), 4 for code 2 (quarter), 2 for code 3 (eighth) and 1 for code 4 (sixteenth). The new index appears at index_o on the second clock edge after the first edge that samples step_i high.
- R3: With direction 0, each detected rising step edge subtracts the increment from the index.
- R4: Changing dir_i with no step edge leaves the index and all setpoint outputs unchanged.
- R5: A step input held high for many cycles produces exactly one move.
- R6: mag_a_o equals round(100·|sin(index·2π/64)|).
- R7: mag_b_o equals round(100·|cos(index·2π/64)|), which is the winding A value at index+16.
- R8: pol_a_o is 1 when index bit 5 is 0. pol_b_o is 1 when bit 5 of (index+16) mod 64 is 0.
- R9: full_step_o is 1 exactly when the resolution code sampled on the previous clock edge is 0.
- R10: The index wraps modulo 64 in both directions.
- R11: Resolution codes 5, 6 and 7 move the index by 1, the same as code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Step pulse; the index moves on its rising edge |
| dir_i | input | 1 | Direction level: 1 counts up, 0 counts down |
| res_sel_i | input | 3 | Resolution code (0 full through 4 sixteenth) |
| index_o | output | 6 | Current electrical position |
| mag_a_o | output | 8 | Winding A magnitude in percent |
| pol_a_o | output | 1 | Winding A polarity (1 = forward) |
| mag_b_o | output | 8 | Winding B magnitude in percent |
| pol_b_o | output | 1 | Winding B polarity (1 = forward) |
| full_step_o | output | 1 | Full-step mode flag for the decay selector |

## Verification
A corrupted index shows up at the ports right away. The error appears in index_o and in both magnitude and polarity pairs in the same cycle. It then persists, because every later step is relative to that index. A wrong increment, or a direction sampled out of step with the step edge, produces the wrong index two cycles after the synchronised edge. A missed or repeated edge detection leaves an offset that no later step corrects. Quadrant mirroring errors show up only at particular positions, so the stimulus visits every quadrant and both wrap points.

// File: rtl/microstep_pkg.sv
package microstep_pkg;
  localparam int unsigned IDX_W  = 6;
  localparam int unsigned OFF_W  = IDX_W - 2;
  localparam int unsigned QTR    = 1 << OFF_W;
  localparam int unsigned MAG_W  = 8;
  localparam int unsigned RES_W  = 3;
  localparam logic [IDX_W-1:0] HOME_IDX = IDX_W'(QTR / 2);

  typedef enum logic [RES_W-1:0] {
    RES_FULL    = 3'd0,
    RES_HALF    = 3'd1,
    RES_QUARTER = 3'd2,
    RES_EIGHTH  = 3'd3,
    RES_SIXT    = 3'd4
  } res_e;
endpackage

// File: rtl/step_sync.sv
module step_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic dir_i,
  output logic rise_o,
  output logic dir_o
);
  logic [STAGES-1:0] step_q;
  logic [STAGES-1:0] dir_q;
  logic              step_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q[0] <= 1'b0;
      dir_q[0]  <= 1'b1;
    end else begin
      step_q[0] <= step_i;
      dir_q[0]  <= dir_i;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        step_q[s] <= 1'b0;
        dir_q[s]  <= 1'b1;
      end else begin
        step_q[s] <= step_q[s-1];
        dir_q[s]  <= dir_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_prev_q <= 1'b0;
    else         step_prev_q <= step_q[STAGES-1];
  end

  assign rise_o = step_q[STAGES-1] & ~step_prev_q;
  assign dir_o  = dir_q[STAGES-1];

  // R5: a detected edge lasts a single cycle
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/index_counter.sv
module index_counter
  import microstep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             fwd_i,
  input  logic [RES_W-1:0] res_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             full_o
);
  logic [RES_W-1:0] res_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= RES_SIXT;
    else         res_q <= res_i;
  end

  always_comb begin
    unique case (res_q)
      RES_FULL:    inc = IDX_W'(QTR);
      RES_HALF:    inc = IDX_W'(QTR / 2);
      RES_QUARTER: inc = IDX_W'(QTR / 4);
      RES_EIGHTH:  inc = IDX_W'(QTR / 8);
      default:     inc = IDX_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= HOME_IDX;
    else if (adv_i) idx_q <= fwd_i ? idx_q + inc : idx_q - inc;
  end

  assign idx_o  = idx_q;
  assign full_o = (res_q == RES_FULL);

  a_r2_fwd_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && fwd_i) |=> idx_q == IDX_W'($past(idx_q) + $past(inc)));
  a_r3_rev_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !fwd_i) |=> idx_q == IDX_W'($past(idx_q) - $past(inc)));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_q));
  a_r9_full_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> $onehot0(inc) && inc[OFF_W]);
endmodule

// File: rtl/winding_lookup.sv
module winding_lookup
  import microstep_pkg::*;
#(
  parameter logic [IDX_W-1:0] OFFSET = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             pol_o
);
  logic [IDX_W-1:0] pos;
  logic [OFF_W:0]   qidx;

  function automatic logic [MAG_W-1:0] qsine(input logic [OFF_W:0] k);
    case (k)
      5'd0:  return 8'd0;
      5'd1:  return 8'd10;
      5'd2:  return 8'd20;
      5'd3:  return 8'd29;
      5'd4:  return 8'd38;
      5'd5:  return 8'd47;
      5'd6:  return 8'd56;
      5'd7:  return 8'd63;
      5'd8:  return 8'd71;
      5'd9:  return 8'd77;
      5'd10: return 8'd83;
      5'd11: return 8'd88;
      5'd12: return 8'd92;
      5'd13: return 8'd96;
      5'd14: return 8'd98;
      5'd15: return 8'd100;
      default: return 8'd100;
    endcase
  endfunction

  assign pos = idx_i + OFFSET;

  // odd quadrants read the table mirrored
  always_comb begin
    if (pos[OFF_W]) qidx = (OFF_W+1)'(QTR) - {1'b0, pos[OFF_W-1:0]};
    else            qidx = {1'b0, pos[OFF_W-1:0]};
  end

  assign mag_o = qsine(qidx);
  assign pol_o = ~pos[IDX_W-1];
endmodule

// File: rtl/microstep_indexer.sv
module microstep_indexer
  import microstep_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic [RES_W-1:0] res_sel_i,
  output logic [IDX_W-1:0] index_o,
  output logic [MAG_W-1:0] mag_a_o,
  output logic             pol_a_o,
  output logic [MAG_W-1:0] mag_b_o,
  output logic             pol_b_o,
  output logic             full_step_o
);
  logic             step_rise;
  logic             dir_s;
  logic [IDX_W-1:0] idx;

  step_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .dir_i  (dir_i),
    .rise_o (step_rise),
    .dir_o  (dir_s)
  );

  index_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (step_rise),
    .fwd_i  (dir_s),
    .res_i  (res_sel_i),
    .idx_o  (idx),
    .full_o (full_step_o)
  );

  winding_lookup #(.OFFSET('0)) u_wind_a (
    .idx_i (idx),
    .mag_o (mag_a_o),
    .pol_o (pol_a_o)
  );

  winding_lookup #(.OFFSET(IDX_W'(QTR))) u_wind_b (
    .idx_i (idx),
    .mag_o (mag_b_o),
    .pol_o (pol_b_o)
  );

  assign index_o = idx;

  // R7: windings stay in quadrature
  a_r7_quadrature: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_a_o == 8'd100) |-> (mag_b_o <= 8'd10));
  a_r6_peak_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mag_a_o == 8'd0) |-> (mag_b_o == 8'd100));
  a_r1_home: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (index_o == HOME_IDX));
endmodule

// File: tb/microstep_indexer_test.sv
`timescale 1ns/1ps
module microstep_indexer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       step_i = 1'b0;
  logic       dir_i = 1'b1;
  logic [2:0] res_sel_i = 3'd4;
  logic [5:0] index_o;
  logic [7:0] mag_a_o, mag_b_o;
  logic       pol_a_o, pol_b_o, full_step_o;

  int checks = 0;
  int errors = 0;

  microstep_indexer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .dir_i(dir_i),
    .res_sel_i(res_sel_i), .index_o(index_o), .mag_a_o(mag_a_o),
    .pol_a_o(pol_a_o), .mag_b_o(mag_b_o), .pol_b_o(pol_b_o),
    .full_step_o(full_step_o)
  );

  always #2 clk_i = ~clk_i;

  // {res, dir, expected index}
  localparam int NVEC = 14;
  localparam logic [9:0] VEC [NVEC] = '{
    {3'd4, 1'b1, 6'd9},  {3'd4, 1'b1, 6'd10}, {3'd3, 1'b1, 6'd12},
    {3'd2, 1'b1, 6'd16}, {3'd1, 1'b1, 6'd24}, {3'd0, 1'b1, 6'd40},
    {3'd0, 1'b1, 6'd56}, {3'd0, 1'b1, 6'd8},  {3'd1, 1'b0, 6'd0},
    {3'd4, 1'b0, 6'd63}, {3'd3, 1'b0, 6'd61}, {3'd7, 1'b1, 6'd62},
    {3'd5, 1'b0, 6'd61}, {3'd2, 1'b1, 6'd1}
  };

  function automatic int exp_mag(input int idx, input bit cosine);
    real ang, v;
    ang = 2.0 * 3.14159265358979 * real'(idx) / 64.0;
    v = cosine ? $cos(ang) : $sin(ang);
    if (v < 0.0) v = -v;
    return $rtoi(100.0 * v + 0.5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req, input int idx);
    chk({req, " index"}, index_o, idx);
    chk("R6 mag_a", mag_a_o, exp_mag(idx, 1'b0));
    chk("R7 mag_b", mag_b_o, exp_mag(idx, 1'b1));
    chk("R8 pol_a", pol_a_o, (idx & 32) == 0);
    chk("R8 pol_b", pol_b_o, (((idx + 16) % 64) & 32) == 0);
  endtask

  task automatic pulse(input int high_cycles);
    step_i = 1'b1;
    repeat (high_cycles) @(negedge clk_i);
    step_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk_outputs("R1", 8);
    chk("R1 full_step", full_step_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 R3 R10 R11 vector walk
    for (int i = 0; i < NVEC; i++) begin
      res_sel_i = VEC[i][9:7];
      dir_i     = VEC[i][6];
      repeat (3) @(negedge clk_i);
      pulse(4);
      chk_outputs(VEC[i][6] ? "R2" : "R3", int'(VEC[i][5:0]));
    end

    // R4 direction toggles without a step edge
    for (int k = 0; k < 6; k++) begin
      dir_i = ~dir_i;
      repeat (5) @(negedge clk_i);
    end
    chk_outputs("R4", 1);

    // R5 long high step gives one move of 1
    dir_i = 1'b1; res_sel_i = 3'd4;
    repeat (3) @(negedge clk_i);
    pulse(40);
    chk_outputs("R5", 2);

    // R9 full-step flag follows resolution after one edge
    res_sel_i = 3'd0;
    @(negedge clk_i);
    chk("R9 full set", full_step_o, 1);
    res_sel_i = 3'd1;
    @(negedge clk_i);
    chk("R9 full clear", full_step_o, 0);

    // R10 full step wrap backward from 2
    res_sel_i = 3'd0; dir_i = 1'b0;
    repeat (3) @(negedge clk_i);
    pulse(4);
    chk_outputs("R10", 50);

    // R1 reset mid-run returns home
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk_outputs("R1", 8);
    chk("R1 full_step", full_step_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule